// File: doc/BRIEF.md
# Master Interrupt Status Controller

This block sits between a bus transfer engine and the interrupt fabric of a chip. The engine raises single-cycle event pulses for completions, FIFO service requests and errors. Each pulse sets a sticky per-event status bit. A per-event enable mask selects which events are allowed to raise the master summary bit, and a global enable gates that summary onto the single interrupt line. Software acknowledges events in two steps: it clears the per-event bits by writing ones to them, and it clears the summary bit the same way.

Register access uses a plain valid strobe with no back-pressure. The block accepts a request in every cycle. A read returns its data with `rsp_valid` exactly one cycle later. A self-clearing soft-reset control empties the status bits, the mask, the summary and the engine FIFOs (through `fifo_flush`) over a fixed number of cycles. Software can poll it until it reads back zero.

Register word addresses: 0 mode control (bit 0 master, bit 1 slave, bit 2 bus monitor), 1 top status (bit 0 master summary, bit 1 slave summary), 2 top enable (bit 0 master interrupt enable), 3 event status, 4 mask, 5 mask-set, 6 mask-clear, 7 soft reset (bit 0). Event indices: 0 address NAK, 1 data NAK, 2 arbitration lost, 3 invalid parameter, 4 timeout, 5 receive service, 6 transmit service, 7 manual-mode done, 8 automatic-mode done, 9 stop done.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq`, `fifo_flush` and `rsp_valid` are 0 and `mode_en` is 0.
- R2: A read request is answered with `rsp_valid`=1 and its data one cycle later. Writes and idle cycles give `rsp_valid`=0. Addresses 8 to 15 and the mask-set and mask-clear addresses read 0, and writes to addresses 8 to 15 change nothing.
- R3: Bits 2:0 of address 0 are read/write and drive `mode_en` (bit 0 master, bit 1 slave, bit 2 bus monitor).
- R4: An `evt_in[k]` pulse sets event status bit k whatever the mask holds. Writing 1 to bit k of address 3 clears it, and writing 0 leaves it. If a pulse and a clear hit the same bit in the same cycle, the bit stays set.
- R5: A write to address 4 loads the mask. A write to address 5 sets the mask bits written as 1. A write to address 6 clears the mask bits written as 1. Only bits 9:0 are stored.
- R6: The master summary (address 1 bit 0) becomes 1 at the clock edge where an event pulse arrives whose mask bit is 1. It also becomes 1 at the edge where a mask write newly enables a bit whose status is already pending. A pulse on a masked event leaves it unchanged.
- R7: Writing 1 to address 1 bit 0 clears the summary, and writing 0 there has no effect. When the clear and a new enabled event (R6) fall in the same cycle, the summary stays 1.
- R8: `irq` is 1 exactly while the summary is 1 and address 2 bit 0 is 1.
- R9: Address 3 bit 31 reads 1 whenever any of the error events (bits 0 to 4) is pending, regardless of the mask.
- R10: Writing 1 to address 7 bit 0 starts a soft reset that lasts 4 cycles (RST_CYCLES). During it, address 7 bit 0 reads 1 and `fifo_flush` is 1. The status bits, the mask and the summary are cleared, and event pulses and writes to them are ignored. Afterwards bit 0 reads 0. Mode control and top enable keep their values.
- R11: Address 1 bit 1 (slave summary) always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 4 | Register word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| evt_in | input | 10 | Event pulses from the transfer engine |
| irq | output | 1 | Master interrupt line |
| fifo_flush | output | 1 | High while a soft reset runs |
| mode_en | output | 3 | Master, slave and bus-monitor enables |

## Verification
The bench goes after the same-cycle collisions. One is an event pulse landing on a bit that software is clearing, and another is a new enabled event landing on the cycle the summary is acknowledged. A design that lets the clear win would lose an interrupt. It also enables a mask bit over an already pending status. A design that only watches incoming pulses would then never interrupt. Soft reset is checked for its exact length, for ignoring events and writes while it runs, and for sparing the mode and enable registers. A wrong counter would show up as a short or long `fifo_flush` or a stale poll value.

// File: rtl/isc_pkg.sv
`timescale 1ns/100ps
package isc_pkg;
  localparam int DW   = 32;
  localparam int AW   = 4;
  localparam int NREG = 8;

  typedef enum logic [2:0] {
    RG_MODE  = 3'd0,
    RG_TOPST = 3'd1,
    RG_TOPEN = 3'd2,
    RG_EVST  = 3'd3,
    RG_MASK  = 3'd4,
    RG_MSET  = 3'd5,
    RG_MCLR  = 3'd6,
    RG_SRST  = 3'd7
  } reg_e;

  // bit positions software decodes
  localparam int TOP_MST_BIT = 0;
  localparam int TOP_SLV_BIT = 1;
  localparam int ERR_ANY_BIT = 31;
  localparam int MODE_W      = 3;
endpackage

// File: rtl/isc_decode.sv
`timescale 1ns/100ps
module isc_decode #(
  parameter int AW   = 4,
  parameter int NREG = 8
) (
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  output logic [NREG-1:0] wr_sel,
  output logic [NREG-1:0] rd_sel
);
  for (genvar i = 0; i < NREG; i++) begin : g_sel
    logic hit;
    assign hit       = req_valid && (req_addr == AW'(i));
    assign wr_sel[i] = hit && req_write;
    assign rd_sel[i] = hit && !req_write;
  end
endmodule

// File: rtl/isc_soft_reset.sv
`timescale 1ns/100ps
module isc_soft_reset #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain_q <= '0;
    else if (start_i)         remain_q <= CW'(RST_CYCLES);
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
  end

  assign busy_o = (remain_q != '0);
endmodule

// File: rtl/isc_event_bank.sv
`timescale 1ns/100ps
module isc_event_bank #(
  parameter int NEV = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic [NEV-1:0] evt_i,
  input  logic           st_w1c_i,
  input  logic           mask_load_i,
  input  logic           mask_set_i,
  input  logic           mask_clr_i,
  input  logic [NEV-1:0] wdata_i,
  output logic [NEV-1:0] stat_o,
  output logic [NEV-1:0] mask_o,
  output logic           summ_set_o
);
  logic [NEV-1:0] stat_q, mask_q, stat_d, mask_d, hit;

  for (genvar k = 0; k < NEV; k++) begin : g_bit
    always_comb begin
      if (clr_i)            mask_d[k] = 1'b0;
      else if (mask_load_i) mask_d[k] = wdata_i[k];
      else if (mask_set_i)  mask_d[k] = mask_q[k] | wdata_i[k];
      else if (mask_clr_i)  mask_d[k] = mask_q[k] & ~wdata_i[k];
      else                  mask_d[k] = mask_q[k];
    end

    // a new pulse beats a same-cycle write-1 clear
    assign stat_d[k] = !clr_i && (evt_i[k] || (stat_q[k] && !(st_w1c_i && wdata_i[k])));

    // enabled arrival, or enable newly opened over a pending bit
    assign hit[k] = (evt_i[k] && mask_q[k]) || (mask_d[k] && !mask_q[k] && stat_q[k]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q[k] <= 1'b0;
        mask_q[k] <= 1'b0;
      end else begin
        stat_q[k] <= stat_d[k];
        mask_q[k] <= mask_d[k];
      end
    end
  end

  assign summ_set_o = !clr_i && (|hit);
  assign stat_o     = stat_q;
  assign mask_o     = mask_q;
endmodule

// File: rtl/irq_status_ctrl.sv
`timescale 1ns/100ps
module irq_status_ctrl
  import isc_pkg::*;
#(
  parameter int NEV        = 10,
  parameter int RST_CYCLES = 4,
  parameter logic [NEV-1:0] ERR_MASK = NEV'(5'b11111)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  input  logic [NEV-1:0] evt_in,
  output logic           irq,
  output logic           fifo_flush,
  output logic [2:0]     mode_en
);
  logic [NREG-1:0] wr_sel, rd_sel;
  logic [NEV-1:0]  stat_q, mask_q;
  logic            summ_q, summ_set, topen_q, busy, sr_start, clr;
  logic [MODE_W-1:0] mode_q;
  logic [DW-1:0]   rd_d;

  isc_decode #(.AW(AW), .NREG(NREG)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .wr_sel    (wr_sel),
    .rd_sel    (rd_sel)
  );

  assign sr_start = wr_sel[RG_SRST] && req_wdata[0] && !busy;
  assign clr      = sr_start || busy;

  isc_soft_reset #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (sr_start),
    .busy_o  (busy)
  );

  isc_event_bank #(.NEV(NEV)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr),
    .evt_i       (evt_in),
    .st_w1c_i    (wr_sel[RG_EVST]),
    .mask_load_i (wr_sel[RG_MASK]),
    .mask_set_i  (wr_sel[RG_MSET]),
    .mask_clr_i  (wr_sel[RG_MCLR]),
    .wdata_i     (req_wdata[NEV-1:0]),
    .stat_o      (stat_q),
    .mask_o      (mask_q),
    .summ_set_o  (summ_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      summ_q  <= 1'b0;
      topen_q <= 1'b0;
      mode_q  <= '0;
    end else begin
      if (clr)                 summ_q <= 1'b0;
      else if (summ_set)       summ_q <= 1'b1;
      else if (wr_sel[RG_TOPST] && req_wdata[TOP_MST_BIT]) summ_q <= 1'b0;
      if (wr_sel[RG_TOPEN])    topen_q <= req_wdata[0];
      if (wr_sel[RG_MODE])     mode_q  <= req_wdata[MODE_W-1:0];
    end
  end

  always_comb begin
    rd_d = '0;
    if (rd_sel[RG_MODE])  rd_d[MODE_W-1:0] = mode_q;
    if (rd_sel[RG_TOPST]) begin
      rd_d[TOP_MST_BIT] = summ_q;
      rd_d[TOP_SLV_BIT] = 1'b0;
    end
    if (rd_sel[RG_TOPEN]) rd_d[0] = topen_q;
    if (rd_sel[RG_EVST]) begin
      rd_d[NEV-1:0]     = stat_q;
      rd_d[ERR_ANY_BIT] = |(stat_q & ERR_MASK);
    end
    if (rd_sel[RG_MASK])  rd_d[NEV-1:0] = mask_q;
    if (rd_sel[RG_SRST])  rd_d[0] = busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= rd_d;
    end
  end

  assign irq        = summ_q && topen_q;
  assign fifo_flush = busy;
  assign mode_en    = mode_q;
endmodule

// File: rtl/irq_status_ctrl_chk.sv
`timescale 1ns/100ps
module irq_status_ctrl_chk #(
  parameter int NEV        = 10,
  parameter int RST_CYCLES = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_write,
  input logic [3:0]     req_addr,
  input logic           req_wd0,
  input logic [NEV-1:0] evt_in,
  input logic           rsp_valid,
  input logic           irq,
  input logic           fifo_flush,
  input logic [NEV-1:0] stat_q,
  input logic [NEV-1:0] mask_q,
  input logic           summ_q
);
  localparam int FW = $clog2(RST_CYCLES + 2);
  logic [FW-1:0] flush_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flush_run <= '0;
    else if (fifo_flush) flush_run <= (flush_run == FW'(RST_CYCLES + 1)) ? flush_run : flush_run + 1'b1;
    else                 flush_run <= '0;
  end

  p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt_in) && !fifo_flush && !(req_valid && req_write && req_addr == 4'd7 && req_wd0))
    |=> ((stat_q & $past(evt_in)) == $past(evt_in)));

  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!summ_q && !req_valid && ((evt_in & mask_q) == '0)) |=> !summ_q);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 4'd1 && req_wd0 && ((evt_in & mask_q) == '0)) |=> !summ_q);

  p_enable_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 4'd2 && !req_wd0) |=> !irq);

  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> (stat_q == '0 && mask_q == '0 && !summ_q));

  p_flush_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_run <= FW'(RST_CYCLES));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.NEV(NEV), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_wd0    (req_wdata[0]),
  .evt_in     (evt_in),
  .rsp_valid  (rsp_valid),
  .irq        (irq),
  .fifo_flush (fifo_flush),
  .stat_q     (stat_q),
  .mask_q     (mask_q),
  .summ_q     (summ_q)
);

// File: tb/irq_status_ctrl_test.sv
`timescale 1ns/100ps
module irq_status_ctrl_test;
  localparam int NEV = 10;
  localparam int RST = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_write, rsp_valid, irq, fifo_flush;
  logic [3:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata, last_rd;
  logic [NEV-1:0] evt_in;
  logic [2:0] mode_en;

  int checks = 0, errors = 0;
  bit done = 0;

  irq_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .evt_in(evt_in), .irq(irq),
    .fifo_flush(fifo_flush), .mode_en(mode_en)
  );

  // reference state, from the requirements
  logic [2:0] m_mode;
  logic m_topen, m_summ;
  logic [NEV-1:0] m_stat, m_mask;
  int m_bcnt;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] mread(input logic [3:0] a);
    logic [31:0] r = '0;
    case (a)
      4'd0: r[2:0] = m_mode;
      4'd1: r[0] = m_summ;
      4'd2: r[0] = m_topen;
      4'd3: begin r[NEV-1:0] = m_stat; r[31] = |m_stat[4:0]; end
      4'd4: r[NEV-1:0] = m_mask;
      4'd7: r[0] = (m_bcnt != 0);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string rtag(input logic [3:0] a);
    case (a)
      4'd0: return "R3 read";
      4'd1: return "R7 R11 read";
      4'd2: return "R8 read";
      4'd3: return "R4 R9 read";
      4'd4: return "R5 read";
      4'd7: return "R10 read";
      default: return "R2 read";
    endcase
  endfunction

  task automatic mstep(input bit v, input bit w, input logic [3:0] a, input logic [31:0] d,
                       input logic [NEV-1:0] e);
    bit wr = v && w;
    bit busy = (m_bcnt != 0);
    bit start = wr && a == 4'd7 && d[0] && !busy;
    bit clr = start || busy;
    logic [NEV-1:0] mn = m_mask;
    bit set;
    if (wr && a == 4'd4) mn = d[NEV-1:0];
    else if (wr && a == 4'd5) mn = m_mask | d[NEV-1:0];
    else if (wr && a == 4'd6) mn = m_mask & ~d[NEV-1:0];
    set = (|(e & m_mask)) || (|(mn & ~m_mask & m_stat));
    if (clr) begin
      m_stat = '0; m_mask = '0; m_summ = 0;
    end else begin
      m_summ = set || (m_summ && !(wr && a == 4'd1 && d[0]));
      m_stat = e | (m_stat & ~((wr && a == 4'd3) ? d[NEV-1:0] : '0));
      m_mask = mn;
    end
    if (wr && a == 4'd0) m_mode = d[2:0];
    if (wr && a == 4'd2) m_topen = d[0];
    if (start) m_bcnt = RST;
    else if (m_bcnt != 0) m_bcnt--;
  endtask

  task automatic cyc(input bit v, input bit w, input logic [3:0] a, input logic [31:0] d,
                     input logic [NEV-1:0] e);
    bit isrd = v && !w;
    logic [31:0] er = mread(a);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; evt_in = e;
    @(posedge clk);
    #1 mstep(v, w, a, d, e);
    @(negedge clk);
    req_valid = 0; evt_in = '0;
    chk("R2 rsp_valid", 32'(rsp_valid), 32'(isrd));
    if (isrd) begin
      chk(rtag(a), rsp_rdata, er);
      last_rd = rsp_rdata;
    end
    chk("R8 irq", 32'(irq), 32'(m_summ && m_topen));
    chk("R10 fifo_flush", 32'(fifo_flush), 32'(m_bcnt != 0));
    chk("R3 mode_en", 32'(mode_en), 32'(m_mode));
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [NEV-1:0] e = '0);
    cyc(1, 1, a, d, e);
  endtask
  task automatic rd(input logic [3:0] a);
    cyc(1, 0, a, '0, '0);
  endtask
  task automatic idle(input logic [NEV-1:0] e = '0);
    cyc(0, 0, 4'd0, '0, e);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1C5A_0F17));
    m_mode = 0; m_topen = 0; m_summ = 0; m_stat = 0; m_mask = 0; m_bcnt = 0;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; evt_in = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 fifo_flush", 32'(fifo_flush), 0);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 mode_en", 32'(mode_en), 0);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a));
      chk("R1 R2 reset read", last_rd, 32'h0);
    end

    // R3 mode bits
    wr(4'd0, 32'hFFFF_FFF5); rd(4'd0);
    chk("R3 mode", last_rd, 32'h5);
    chk("R3 mode_en pin", 32'(mode_en), 32'h5);

    // R2 unmapped write is dropped
    wr(4'd12, 32'hFFFF_FFFF); rd(4'd4);
    chk("R2 unmapped write", last_rd, 32'h0);

    // R6 R8 enabled event
    wr(4'd2, 1); wr(4'd5, 32'h004); idle(10'h004);
    chk("R8 irq on enabled event", 32'(irq), 1);
    rd(4'd1);
    chk("R6 summary set", last_rd, 32'h1);

    // R7 write 0 no effect, write 1 clears
    wr(4'd1, 0); rd(4'd1);
    chk("R7 write zero keeps", last_rd, 32'h1);
    wr(4'd1, 1); rd(4'd1);
    chk("R7 ack clears", last_rd, 32'h0);

    // R6 masked event does not set summary
    idle(10'h080); rd(4'd1);
    chk("R6 masked event quiet", last_rd, 32'h0);
    // R6 enabling pending bit sets summary
    wr(4'd5, 32'h080); rd(4'd1);
    chk("R6 mask over pending", last_rd, 32'h1);

    // R7 ack collides with new enabled event
    wr(4'd1, 1, 10'h004); rd(4'd1);
    chk("R7 event wins ack", last_rd, 32'h1);

    // R4 clear collides with same-bit pulse; R9 error summary bit
    wr(4'd3, 32'h3FF, 10'h004); rd(4'd3);
    chk("R4 pulse wins clear", last_rd, 32'h8000_0004);
    wr(4'd6, 32'h004); rd(4'd3);
    chk("R9 error bit ignores mask", last_rd[31], 1);
    wr(4'd3, 32'h004); rd(4'd3);
    chk("R9 error bit drops", last_rd, 32'h0);

    // R5 set/clear/load, width
    wr(4'd4, 32'hFFFF_FFFF); rd(4'd4);
    chk("R5 load width", last_rd, 32'h3FF);
    wr(4'd6, 32'h0F0); rd(4'd4);
    chk("R5 clear strobe", last_rd, 32'h30F);
    wr(4'd5, 32'h020); rd(4'd4);
    chk("R5 set strobe", last_rd, 32'h32F);

    // R11 slave summary bit
    idle(10'h001); rd(4'd1);
    chk("R11 slave bit zero", last_rd & 32'h2, 32'h0);

    // R10 soft reset
    idle(10'h3FF);
    wr(4'd7, 1);
    rd(4'd7);
    chk("R10 busy polls one", last_rd, 32'h1);
    idle(10'h3FF);
    wr(4'd4, 32'h3FF);
    idle();
    rd(4'd7);
    chk("R10 done polls zero", last_rd, 32'h0);
    rd(4'd3);
    chk("R10 status cleared", last_rd, 32'h0);
    rd(4'd4);
    chk("R10 mask cleared", last_rd, 32'h0);
    rd(4'd0);
    chk("R10 mode kept", last_rd, 32'h5);
    rd(4'd2);
    chk("R10 enable kept", last_rd, 32'h1);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      int sel = $urandom_range(0, 9);
      logic [NEV-1:0] e = ($urandom_range(0, 3) == 0) ? NEV'(1 << $urandom_range(0, NEV - 1)) : '0;
      logic [3:0] a = 4'($urandom_range(0, 8));
      logic [31:0] d = $urandom;
      if (a == 4'd7 && $urandom_range(0, 7) != 0) d[0] = 1'b0;
      if (sel < 4)      cyc(1, 0, a, '0, e);
      else if (sel < 8) cyc(1, 1, a, d, e);
      else              cyc(0, 0, 4'd0, '0, e);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule